// File: doc/BRIEF.md
# Multi-Bank GPIO Interrupt Controller

This block serves several banks of general-purpose pins, each bank up to 32 pins wide. Each bank has a 32-byte register window. Through that window software sets the output enables and output data of the pins, reads the pin levels, and chooses a trigger for every pin. A pin can trigger on a rising edge, on a falling edge, on both edges, or on an active-high level. Pin inputs are synchronized before any detection. Each detected event sets a sticky status bit, which software clears by writing a one to it.

Every status bit that is also enabled in its bank's mask feeds one shared interrupt line for the whole block. A second line signals wake-up while the system is suspended. During suspend only pins that are both masked in and marked wake-capable can raise the wake line, and the shared interrupt line stays low.

The register port is a plain single-cycle port. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Bank N's window starts at byte address N*0x20; bits [4:2] of the address pick the register: 0x00 output enable, 0x04 data (write sets output data, read returns synchronized pin levels), 0x08 interrupt mask, 0x0C status, 0x10 edge select, 0x14 both-edge, 0x18 level, 0x1C wake enable; all registers reset to 0, and reads from a window past the last bank return 0.
- R2: Each bank's output-enable and data registers drive that bank's 32-bit slice of `pins_oe` and `pins_out`.
- R3: With both-edge 0, level 0 and edge select 1, a pin's status bit sets on a rising input and not on a falling one; the status bit is set after the third rising clock edge following the input change.
- R4: With both-edge 0, level 0 and edge select 0, a pin's status bit sets on a falling input and not on a rising one.
- R5: With both-edge 1, the status bit sets on either input edge whatever the edge-select bit holds.
- R6: With both-edge 0 and level 1, the status bit sets while the synchronized input is high (edge select is then ignored); a clearing write does not clear it while the input stays high, and it clears once the input is low.
- R7: Status bits are sticky and write-one-to-clear: writing 1 clears a bit, writing 0 leaves it unchanged.
- R8: Pins at positions at or above the parameter `BANK_W` never set status, in any trigger mode.
- R9: `irq` is high when any bank has a pin with both status and mask at 1; a pin whose mask bit is 0 does not raise it.
- R10: While `suspend` is high, `irq` is low and `wake` is high exactly when some pin has status, mask and wake-enable all at 1; while `suspend` is low, `wake` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pins_in | input | NUM_BANKS*32 | Asynchronous pin levels, bank 0 in the low bits |
| pins_out | output | NUM_BANKS*32 | Output data for the pins |
| pins_oe | output | NUM_BANKS*32 | Output enables for the pins |
| suspend | input | 1 | System suspend indication |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake request during suspend |

## Verification
The bench builds the block with three banks and `BANK_W` set to 20. Three banks is not a power of two, so the address decoder has a bank field in which one value, 3, has no bank behind it. A read from that empty window checks that it returns zero. Setting `BANK_W` below 32 leaves twelve pin positions in each bank that are decoded but not used, so a pin at position 25 can be toggled in both-edge mode to show that it never sets status. The trigger modes are spread over different banks, which checks that each window's decoding is independent and that every bank feeds the merged interrupt line.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register selectors and window geometry for the GPIO
// interrupt controller. Assumes 32-bit registers on word-aligned addresses.
package gpio_irq_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned WIN_SHIFT = 5;   // 32-byte window per bank

    typedef enum logic [2:0] {
        SEL_OE    = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_STAT  = 3'd3,
        SEL_RISE  = 3'd4,
        SEL_BOTH  = 3'd5,
        SEL_LVL   = 3'd6,
        SEL_WAKE  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchronizer followed by a history flop. It outputs the
// synchronized level and its value one cycle earlier, which the edge
// detector compares. Assumes the inputs are asynchronous to clk.
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;

    // Purpose: capture, resolve and remember the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= raw_in;
            cur    <= meta_q;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
// Module: gpio_trig_detect
// Purely combinational per-pin event decode. Both-edge takes precedence,
// then level, then edge select (1 = rising, 0 = falling). Pins at or
// above BANK_W are forced to never produce an event.
module gpio_trig_detect #(
    parameter int unsigned BANK_W = 32
) (
    input  logic [31:0] cur,
    input  logic [31:0] prev,
    input  logic [31:0] rise_sel,
    input  logic [31:0] both,
    input  logic [31:0] lvl,
    output logic [31:0] evt
);
    localparam logic [31:0] VALID_MASK =
        (BANK_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << BANK_W) - 32'd1);

    logic [31:0] rise_ev;
    logic [31:0] fall_ev;

    // Purpose: form raw edges and select the configured event per pin.
    always_comb begin
        rise_ev = cur & ~prev;
        fall_ev = ~cur & prev;
        evt = VALID_MASK & (
                  (both & (rise_ev | fall_ev))
                | (~both & lvl & cur)
                | (~both & ~lvl & rise_sel & rise_ev)
                | (~both & ~lvl & ~rise_sel & fall_ev));
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: gpio_bank
// One bank: configuration registers, sticky write-one-to-clear status,
// read mux and the bank's interrupt and wake requests. Assumes the top
// decodes the bank window and presents a register selector.
module gpio_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned BANK_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [31:0] pin_raw,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic        irq_req,
    output logic        wake_req
);
    localparam logic [31:0] VALID_MASK =
        (BANK_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << BANK_W) - 32'd1);

    logic [31:0] oe_q, dout_q, mask_q, status_q, rise_q, both_q, lvl_q, wake_q;
    logic [31:0] cur, prev, evt, clr;

    gpio_in_sync #(.W(32)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_raw),
        .cur    (cur),
        .prev   (prev)
    );

    gpio_trig_detect #(.BANK_W(BANK_W)) det_i (
        .cur      (cur),
        .prev     (prev),
        .rise_sel (rise_q),
        .both     (both_q),
        .lvl      (lvl_q),
        .evt      (evt)
    );

    // Purpose: write-one-to-clear pattern for the status register.
    assign clr = (wr_en && sel == SEL_STAT) ? wdata : 32'd0;

    // Purpose: configuration registers and sticky status (new events win).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= '0; dout_q <= '0; mask_q <= '0; status_q <= '0;
            rise_q <= '0; both_q <= '0; lvl_q <= '0; wake_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | evt;
            if (wr_en) begin
                case (sel)
                    SEL_OE:   oe_q   <= wdata;
                    SEL_DATA: dout_q <= wdata;
                    SEL_MASK: mask_q <= wdata;
                    SEL_RISE: rise_q <= wdata;
                    SEL_BOTH: both_q <= wdata;
                    SEL_LVL:  lvl_q  <= wdata;
                    SEL_WAKE: wake_q <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    // Purpose: register read mux.
    always_comb begin
        case (sel)
            SEL_OE:   rdata = oe_q;
            SEL_DATA: rdata = cur;
            SEL_MASK: rdata = mask_q;
            SEL_STAT: rdata = status_q;
            SEL_RISE: rdata = rise_q;
            SEL_BOTH: rdata = both_q;
            SEL_LVL:  rdata = lvl_q;
            default:  rdata = wake_q;
        endcase
    end

    assign pin_out  = dout_q;
    assign pin_oe   = oe_q;
    assign irq_req  = |(status_q & mask_q);
    assign wake_req = |(status_q & mask_q & wake_q);

    // R8
    unused_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~VALID_MASK) == 32'd0);

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_STAT) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: gpio_irq_ctrl (top)
// Decodes the byte address into a bank window and register, instantiates
// one gpio_bank per bank and merges the bank requests into the shared
// interrupt and the suspend-time wake line. Assumes word-aligned access.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_W    = 32,
    localparam int unsigned BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W   = WIN_SHIFT + BIDX_W,
    localparam int unsigned PIN_W    = NUM_BANKS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PIN_W-1:0]  pins_in,
    output logic [PIN_W-1:0]  pins_out,
    output logic [PIN_W-1:0]  pins_oe,
    input  logic              suspend,
    output logic              irq,
    output logic              wake
);
    logic [BIDX_W-1:0]    bank_idx;
    reg_sel_e             sel;
    logic [31:0]          bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;
    logic [NUM_BANKS-1:0] bank_wake;
    logic                 unused_byte_lanes;

    assign bank_idx          = reg_addr[ADDR_W-1:WIN_SHIFT];
    assign sel               = reg_sel_e'(reg_addr[4:2]);
    assign unused_byte_lanes = ^reg_addr[1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.BANK_W(BANK_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && bank_idx == BIDX_W'(b)),
            .sel      (sel),
            .wdata    (reg_wdata),
            .rdata    (bank_rd[b]),
            .pin_raw  (pins_in[b*REG_W +: REG_W]),
            .pin_out  (pins_out[b*REG_W +: REG_W]),
            .pin_oe   (pins_oe[b*REG_W +: REG_W]),
            .irq_req  (bank_irq[b]),
            .wake_req (bank_wake[b])
        );
    end

    // Purpose: select the addressed bank's read data; empty windows read 0.
    always_comb begin
        reg_rdata = 32'd0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BIDX_W'(b)) reg_rdata = bank_rd[b];
        end
    end

    assign irq  = !suspend && (|bank_irq);
    assign wake = suspend && (|bank_wake);

    // R10
    irq_quiet_in_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> !irq);

    // R10
    wake_only_in_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !suspend |-> !wake);
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected values into a queue; a
// monitor pops and compares them at each falling clock edge.
module gpio_irq_ctrl_tb_top;
    localparam int NB = 3;
    localparam int BW = 20;
    localparam int AW = 7;

    localparam int K_RD   = 0;
    localparam int K_IRQ  = 1;
    localparam int K_WAKE = 2;
    localparam int K_OE1  = 3;
    localparam int K_OUT1 = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NB*32-1:0]  pins_in = '0;
    logic [NB*32-1:0]  pins_out;
    logic [NB*32-1:0]  pins_oe;
    logic              suspend = 1'b0;
    logic              irq;
    logic              wake;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NUM_BANKS(NB), .BANK_W(BW)) dut_i (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .pins_in (pins_in),
        .pins_out (pins_out), .pins_oe (pins_oe), .suspend (suspend),
        .irq (irq), .wake (wake)
    );

    // Monitor: compare every queued expectation against the outputs.
    initial begin
        exp_t        it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = reg_rdata;
                    K_IRQ:   act = {31'd0, irq};
                    K_WAKE:  act = {31'd0, wake};
                    K_OE1:   act = pins_oe[63:32];
                    default: act = pins_out[63:32];
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string req);
        exp_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input int bank, input int off, input logic [31:0] d);
        reg_addr  = AW'(bank * 32 + off);
        reg_wdata = d;
        reg_we    = 1'b1;
        step(1);
        reg_we    = 1'b0;
    endtask

    task automatic chk_rd(input int bank, input int off, input logic [31:0] e, input string req);
        reg_addr = AW'(bank * 32 + off);
        push(K_RD, e, req);
        settle();
    endtask

    task automatic chk_sig(input int kind, input logic e, input string req);
        push(kind, {31'd0, e}, req);
        settle();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk_rd(0, 'h0C, 32'h0, "R1 reset status");
        chk_rd(2, 'h08, 32'h0, "R1 reset mask");
        chk_sig(K_IRQ, 1'b0, "R9 irq after reset");
        chk_sig(K_WAKE, 1'b0, "R10 wake after reset");

        // R2 output enable and data of bank 1
        wr(1, 'h00, 32'h0000_00A5);
        wr(1, 'h04, 32'h1234_005A);
        push(K_OE1, 32'h0000_00A5, "R2 pins_oe bank1");
        push(K_OUT1, 32'h1234_005A, "R2 pins_out bank1");
        settle();
        chk_rd(1, 'h00, 32'h0000_00A5, "R1 oe readback");

        // R1 data read returns synchronized pins; empty window reads 0
        pins_in[3:0] = 4'h9;
        step(3);
        chk_rd(0, 'h04, 32'h0000_0009, "R1 data read");
        chk_rd(3, 'h00, 32'h0, "R1 empty window");
        pins_in[3:0] = 4'h0;
        step(3);
        wr(0, 'h0C, 32'hFFFF_FFFF);
        chk_rd(0, 'h0C, 32'h0, "R4 cleared falling events");

        // R3 rising edge on bank0 pin0, R9 irq, R7 clear
        wr(0, 'h10, 32'h0000_0001);
        wr(0, 'h08, 32'h0000_0001);
        pins_in[0] = 1'b1;
        step(2);
        chk_rd(0, 'h0C, 32'h0, "R3 not yet latched");
        step(1);
        chk_rd(0, 'h0C, 32'h0000_0001, "R3 rising latched");
        chk_sig(K_IRQ, 1'b1, "R9 masked status raises irq");
        wr(0, 'h0C, 32'h0000_0001);
        chk_rd(0, 'h0C, 32'h0, "R7 write one clears");
        chk_sig(K_IRQ, 1'b0, "R9 irq drops");
        pins_in[0] = 1'b0;
        step(3);
        chk_rd(0, 'h0C, 32'h0, "R3 falling ignored");

        // R4 falling edge on bank0 pin1, unmasked
        pins_in[1] = 1'b1;
        step(3);
        chk_rd(0, 'h0C, 32'h0, "R4 rising ignored");
        pins_in[1] = 1'b0;
        step(3);
        chk_rd(0, 'h0C, 32'h0000_0002, "R4 falling latched");
        chk_sig(K_IRQ, 1'b0, "R9 unmasked pin no irq");
        wr(0, 'h0C, 32'h0);
        chk_rd(0, 'h0C, 32'h0000_0002, "R7 write zero keeps");
        wr(0, 'h0C, 32'h0000_0002);

        // R5 both edges on bank2 pin5, edge select set and ignored
        wr(2, 'h14, 32'h0000_0020);
        wr(2, 'h10, 32'h0000_0020);
        wr(2, 'h08, 32'h0000_0020);
        pins_in[64+5] = 1'b1;
        step(3);
        chk_rd(2, 'h0C, 32'h0000_0020, "R5 rise latched");
        chk_sig(K_IRQ, 1'b1, "R9 irq from bank2");
        wr(2, 'h0C, 32'h0000_0020);
        pins_in[64+5] = 1'b0;
        step(3);
        chk_rd(2, 'h0C, 32'h0000_0020, "R5 fall latched");
        wr(2, 'h0C, 32'h0000_0020);

        // R6 level high on bank1 pin2
        wr(1, 'h18, 32'h0000_0004);
        pins_in[32+2] = 1'b1;
        step(3);
        chk_rd(1, 'h0C, 32'h0000_0004, "R6 level latched");
        wr(1, 'h0C, 32'h0000_0004);
        chk_rd(1, 'h0C, 32'h0000_0004, "R6 clear while high");
        pins_in[32+2] = 1'b0;
        step(3);
        wr(1, 'h0C, 32'h0000_0004);
        chk_rd(1, 'h0C, 32'h0, "R6 clears when low");

        // R8 pin 25 beyond BANK_W in both-edge mode
        wr(0, 'h14, 32'h0200_0000);
        wr(0, 'h08, 32'h0200_0001);
        pins_in[25] = 1'b1;
        step(3);
        pins_in[25] = 1'b0;
        step(3);
        chk_rd(0, 'h0C, 32'h0, "R8 unused pin no status");
        chk_sig(K_IRQ, 1'b0, "R8 unused pin no irq");

        // R10 suspend and wake
        pins_in[0] = 1'b1;
        step(3);
        chk_sig(K_IRQ, 1'b1, "R10 irq before suspend");
        suspend = 1'b1;
        chk_sig(K_IRQ, 1'b0, "R10 irq held low");
        chk_sig(K_WAKE, 1'b0, "R10 no wake without enable");
        wr(0, 'h1C, 32'h0000_0001);
        chk_sig(K_WAKE, 1'b1, "R10 wake enabled pin");
        wr(0, 'h08, 32'h0200_0000);
        chk_sig(K_WAKE, 1'b0, "R10 wake needs mask");
        wr(0, 'h08, 32'h0000_0001);
        suspend = 1'b0;
        chk_sig(K_WAKE, 1'b0, "R10 wake low out of suspend");
        chk_sig(K_IRQ, 1'b1, "R10 irq back after suspend");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule